// File: doc/BRIEF.md
# Prefetch Benefit Monitor with Held-Out Address Class

This block decides, window by window, whether a data prefetcher is worth keeping switched on. One fixed residue class of cache block addresses (block address modulo 4 equal to 2) never receives prefetches. That class acts as a permanent control group. Each candidate prefetch address presented to the block gets a registered verdict one cycle later. The verdict says whether the candidate must be dropped, because it falls in the held-out class or because prefetching is currently switched off.

Alongside the candidates, the cache reports access events and miss events, each tagged with its block address. Four saturating counters sort these events into held-out accesses, held-out misses, other accesses and other misses. A free-running timer closes an evaluation window every `WIN_CYCLES` cycles (one million by default). At each window close the two miss rates are compared by cross-multiplication, so no divider is needed. The enable output is then set or cleared, and all counters restart. The held-out class stays suppressed while prefetching is off, so a later window can turn prefetching back on.

Top module: `pf_duel_ctrl`

## Requirements
- R1: While and after reset, `pf_en` is 1 and `drop_valid` is 0.
- R2: A candidate (`cand_valid`=1) produces `drop_valid`=1 on the next clock edge. If its block address has bits [1:0] equal to 2'b10 (address modulo 4 equal to 2), `drop_flag` is 1 regardless of `pf_en`.
- R3: For a candidate whose address bits [1:0] are not 2'b10, `drop_flag` equals the inverse of the `pf_en` value held during the candidate's cycle.
- R4: Decisions happen only on the clock edge that ends every `WIN_CYCLES`-th cycle counted from the first edge after reset is released. `pf_en` changes on no other edge.
- R5: At a decision with both access counts nonzero, `pf_en` becomes 1 exactly when other_misses × held_accesses < held_misses × other_accesses. An equal result (equal miss rates) gives 0.
- R6: At a decision where either the held-out access count or the other access count is zero, `pf_en` keeps its value.
- R7: Access and miss events are counted separately. Each is sorted by its own block address: bits [1:0] equal to 2'b10 go to the held-out class, all others to the other class.
- R8: Each counter saturates at 2^`CNT_W`−1 and does not wrap.
- R9: All counters restart at every decision. Events sampled on the decision edge belong to the following window, and earlier windows leave no trace in later decisions.
- R10: A disabled prefetcher is re-enabled by a later window whose counts satisfy R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cand_valid | input | 1 | A candidate prefetch is presented this cycle |
| cand_blk | input | ADDR_W | Block address of the candidate |
| acc_valid | input | 1 | A cache access event this cycle |
| acc_blk | input | ADDR_W | Block address of the access |
| miss_valid | input | 1 | A cache miss event this cycle |
| miss_blk | input | ADDR_W | Block address of the miss |
| drop_valid | output | 1 | Verdict for the candidate of the previous cycle |
| drop_flag | output | 1 | 1: discard that candidate, 0: let it issue |
| pf_en | output | 1 | Global prefetch enable |

## Verification
A candidate's verdict appears on the edge after the candidate. The driver therefore pushes the expected flag when it drives the candidate. The monitor pops and compares that flag at the falling edge that follows, while `drop_valid` is high. Decisions land on the edge that makes the bench's own count of post-reset edges a multiple of the window length. The bench checks `pf_en` at the falling edge just before that edge, which must still show the old value, and again at the falling edge just after, which must show the new value. Each window's events are driven right after a decision and finish well before the next one. The expected counts, saturation included, and the cross-multiplied verdict are therefore computed from exactly the events of that window.

// File: rtl/pf_duel_pkg.sv
package pf_duel_pkg;
  // Index of each event counter in the counter bank.
  typedef enum int unsigned {
    IX_HELD_ACC  = 0,
    IX_HELD_MISS = 1,
    IX_OTH_ACC   = 2,
    IX_OTH_MISS  = 3
  } ctr_ix_e;

  localparam int NUM_CTR = 4;

  // Which address stream feeds each class selector.
  localparam int SEL_CAND = 0;
  localparam int SEL_ACC  = 1;
  localparam int SEL_MISS = 2;
  localparam int NUM_SEL  = 3;
endpackage

// File: rtl/pf_set_sel.sv
// Decides whether a block address belongs to the held-out class.
module pf_set_sel #(
  parameter int ADDR_W = 32,
  parameter int MOD_W  = 2,
  parameter int RES    = 2
) (
  input  logic [ADDR_W-1:0] blk,
  output logic              held
);
  localparam logic [MOD_W-1:0] RES_V = MOD_W'(RES);

  always_comb held = (blk[MOD_W-1:0] == RES_V);
endmodule

// File: rtl/pf_sat_ctr.sv
// Saturating event counter with a synchronous restart.
module pf_sat_ctr #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (clr) begin
      // The event of the restart cycle opens the new window.
      cnt_q <= {{(W-1){1'b0}}, inc};
    end else if (inc && (cnt_q != MAXV)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt = cnt_q;

  // R8: a full counter stays full until restarted
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == MAXV && !clr) |=> (cnt_q == MAXV));

  // R9: a restart with no event leaves zero
  assert_restart_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (clr && !inc) |=> (cnt_q == '0));

  // R9: a restart with an event leaves one
  assert_restart_one_R9: assert property (@(posedge clk) disable iff (rst)
    (clr && inc) |=> (cnt_q == {{(W-1){1'b0}}, 1'b1}));
endmodule

// File: rtl/pf_win_timer.sv
// Free-running window timer, pulses on the last cycle of each window.
module pf_win_timer #(
  parameter int WIN_CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int TW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(WIN_CYCLES - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb tick = (cnt_q == LAST);

  // R4: the timer never leaves its range
  assert_timer_range_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

  // R4: the window restarts after its last cycle
  assert_timer_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == LAST) |=> (cnt_q == '0));
endmodule

// File: rtl/pf_rate_judge.sv
// Compares two miss rates by cross-multiplication.
module pf_rate_judge #(
  parameter int W = 20
) (
  input  logic [W-1:0] held_acc,
  input  logic [W-1:0] held_miss,
  input  logic [W-1:0] oth_acc,
  input  logic [W-1:0] oth_miss,
  output logic         no_evidence,
  output logic         helps
);
  localparam int PW = 2 * W;

  logic [PW-1:0] oth_side;
  logic [PW-1:0] held_side;

  always_comb begin
    oth_side    = {{W{1'b0}}, oth_miss}  * {{W{1'b0}}, held_acc};
    held_side   = {{W{1'b0}}, held_miss} * {{W{1'b0}}, oth_acc};
    no_evidence = (held_acc == '0) || (oth_acc == '0);
    helps       = (oth_side < held_side);
  end
endmodule

// File: rtl/pf_duel_ctrl.sv
module pf_duel_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 20,
  parameter int WIN_CYCLES = 1000000,
  parameter int MOD_W      = 2,
  parameter int HELD_RES   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cand_valid,
  input  logic [ADDR_W-1:0] cand_blk,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_blk,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_blk,
  output logic              drop_valid,
  output logic              drop_flag,
  output logic              pf_en
);
  import pf_duel_pkg::*;

  logic [ADDR_W-1:0] sel_addr [NUM_SEL];
  logic [NUM_SEL-1:0] sel_held;
  logic [NUM_CTR-1:0] inc_vec;
  logic [CNT_W-1:0]   cnt_arr [NUM_CTR];
  logic               tick;
  logic               no_evidence;
  logic               helps;
  logic               pf_en_q;
  logic               drop_valid_q;
  logic               drop_flag_q;

  always_comb begin
    sel_addr[SEL_CAND] = cand_blk;
    sel_addr[SEL_ACC]  = acc_blk;
    sel_addr[SEL_MISS] = miss_blk;
  end

  // One class selector per address stream.
  for (genvar s = 0; s < NUM_SEL; s++) begin : g_sel
    pf_set_sel #(
      .ADDR_W(ADDR_W),
      .MOD_W (MOD_W),
      .RES   (HELD_RES)
    ) u_sel (
      .blk (sel_addr[s]),
      .held(sel_held[s])
    );
  end

  always_comb begin
    inc_vec[IX_HELD_ACC]  = acc_valid  &  sel_held[SEL_ACC];
    inc_vec[IX_OTH_ACC]   = acc_valid  & ~sel_held[SEL_ACC];
    inc_vec[IX_HELD_MISS] = miss_valid &  sel_held[SEL_MISS];
    inc_vec[IX_OTH_MISS]  = miss_valid & ~sel_held[SEL_MISS];
  end

  pf_win_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
    pf_sat_ctr #(.W(CNT_W)) u_ctr (
      .clk(clk),
      .rst(rst),
      .clr(tick),
      .inc(inc_vec[k]),
      .cnt(cnt_arr[k])
    );
  end

  pf_rate_judge #(.W(CNT_W)) u_judge (
    .held_acc   (cnt_arr[IX_HELD_ACC]),
    .held_miss  (cnt_arr[IX_HELD_MISS]),
    .oth_acc    (cnt_arr[IX_OTH_ACC]),
    .oth_miss   (cnt_arr[IX_OTH_MISS]),
    .no_evidence(no_evidence),
    .helps      (helps)
  );

  // Enable register: updated only at a window close with evidence.
  always_ff @(posedge clk) begin
    if (rst) begin
      pf_en_q <= 1'b1;
    end else if (tick && !no_evidence) begin
      pf_en_q <= helps;
    end
  end

  // Candidate verdict, one cycle after the candidate.
  always_ff @(posedge clk) begin
    if (rst) begin
      drop_valid_q <= 1'b0;
      drop_flag_q  <= 1'b0;
    end else begin
      drop_valid_q <= cand_valid;
      drop_flag_q  <= cand_valid & (sel_held[SEL_CAND] | ~pf_en_q);
    end
  end

  assign pf_en      = pf_en_q;
  assign drop_valid = drop_valid_q;
  assign drop_flag  = drop_flag_q;

  // R2: a held-out candidate is always dropped one cycle later
  assert_held_dropped_R2: assert property (@(posedge clk) disable iff (rst)
    (cand_valid && cand_blk[MOD_W-1:0] == MOD_W'(HELD_RES)) |=> (drop_valid && drop_flag));

  // R2: no verdict without a candidate
  assert_no_spurious_verdict_R2: assert property (@(posedge clk) disable iff (rst)
    !cand_valid |=> !drop_valid);

  // R4: the enable moves only at a window close
  assert_en_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(pf_en_q));

  // R6: an empty access class leaves the enable unchanged
  assert_keep_no_evidence_R6: assert property (@(posedge clk) disable iff (rst)
    (tick && (cnt_arr[IX_HELD_ACC] == '0 || cnt_arr[IX_OTH_ACC] == '0)) |=> $stable(pf_en_q));
endmodule

// File: tb/sim_pf_duel_ctrl.sv
module sim_pf_duel_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int CNT_W      = 5;
  localparam int WIN        = 100;
  localparam int MAXC       = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cand_valid = 1'b0;
  logic [ADDR_W-1:0] cand_blk = '0;
  logic              acc_valid = 1'b0;
  logic [ADDR_W-1:0] acc_blk = '0;
  logic              miss_valid = 1'b0;
  logic [ADDR_W-1:0] miss_blk = '0;
  logic              drop_valid;
  logic              drop_flag;
  logic              pf_en;

  int  n_checks = 0;
  int  n_errors = 0;
  int  edge_n   = 0;
  bit  exp_en   = 1'b1;
  bit  done     = 1'b0;
  bit  exp_q[$];

  pf_duel_ctrl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .WIN_CYCLES(WIN)
  ) u0 (
    .clk(clk), .rst(rst),
    .cand_valid(cand_valid), .cand_blk(cand_blk),
    .acc_valid(acc_valid), .acc_blk(acc_blk),
    .miss_valid(miss_valid), .miss_blk(miss_blk),
    .drop_valid(drop_valid), .drop_flag(drop_flag), .pf_en(pf_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Bench's own count of edges since reset release.
  always @(posedge clk) begin
    if (rst) edge_n <= 0;
    else     edge_n <= edge_n + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d at edge %0d", req, act, expv, edge_n);
    end
  endtask

  // Monitor: pops the expected verdict for each candidate.
  always @(negedge clk) begin
    if (!rst && drop_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected verdict", 1, 0);
      end else begin
        bit e;
        e = exp_q.pop_front();
        check(drop_flag == e, "R2/R3 drop_flag", int'(drop_flag), int'(e));
      end
    end
  end

  function automatic logic [ADDR_W-1:0] held_addr(input int i);
    return 32'h0000_1002 + (ADDR_W'(i) << 2);
  endfunction

  function automatic logic [ADDR_W-1:0] oth_addr(input int i);
    return 32'h0000_3001 + (ADDR_W'(i) << 2) + ADDR_W'((i % 2) * 2);
  endfunction

  // Driver: pushes expected verdicts, drives a burst of candidates.
  task automatic cand_burst(input int n, input int start);
    for (int i = 0; i < n; i++) begin
      logic [ADDR_W-1:0] a;
      bit held;
      a = ADDR_W'(start + i) + 32'h0004_0000;
      held = (a[1:0] == 2'b10);
      @(negedge clk);
      cand_valid = 1'b1;
      cand_blk   = a;
      exp_q.push_back(held | ~exp_en);
    end
    @(negedge clk);
    cand_valid = 1'b0;
    @(negedge clk);
    check(exp_q.size() == 0, "R2 verdict count", exp_q.size(), 0);
  endtask

  function automatic int sat(input int v);
    return (v > MAXC) ? MAXC : v;
  endfunction

  // Expected decision from the counts of one window.
  function automatic bit decide(input int ha, input int hm, input int oa, input int om, input bit cur);
    int sha, shm, soa, som;
    sha = sat(ha); shm = sat(hm); soa = sat(oa); som = sat(om);
    if (sha == 0 || soa == 0) return cur;
    return (som * sha) < (shm * soa);
  endfunction

  // Drive one window of events right after a decision.
  task automatic drive_window(input int ha, input int hm, input int oa, input int om);
    int n;
    n = ((ha + oa) > (hm + om)) ? (ha + oa) : (hm + om);
    for (int i = 0; i < n; i++) begin
      acc_valid  = (i < ha + oa);
      acc_blk    = (i < ha) ? held_addr(i) : oth_addr(i);
      miss_valid = (i < hm + om);
      miss_blk   = (i < hm) ? held_addr(i + 7) : oth_addr(i + 9);
      @(negedge clk);
    end
    acc_valid  = 1'b0;
    miss_valid = 1'b0;
  endtask

  // Check the enable just before and just after the next decision edge.
  task automatic await_decision(input bit new_en, input string req);
    do begin @(posedge clk); #1; end while ((edge_n % WIN) != WIN - 1);
    @(negedge clk);
    check(pf_en == exp_en, "R4 enable held before decision", int'(pf_en), int'(exp_en));
    @(posedge clk); #1;
    exp_en = new_en;
    @(negedge clk);
    check(pf_en == exp_en, req, int'(pf_en), int'(exp_en));
  endtask

  task automatic window(input int ha, input int hm, input int oa, input int om, input string req);
    bit nxt;
    nxt = decide(ha, hm, oa, om, exp_en);
    drive_window(ha, hm, oa, om);
    await_decision(nxt, req);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R1: reset state
    check(pf_en == 1'b1, "R1 pf_en in reset", int'(pf_en), 1);
    check(drop_valid == 1'b0, "R1 drop_valid in reset", int'(drop_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(pf_en == 1'b1, "R1 pf_en after reset", int'(pf_en), 1);

    // R2, R3: verdicts while enabled (only residue 2 dropped)
    cand_burst(8, 0);

    // R6: idle first window keeps the enable
    await_decision(exp_en, "R6 no evidence keeps enable");

    // R5, R7: other lines miss more, prefetching switched off
    window(10, 2, 10, 6, "R5 harmful window disables");

    // R2, R3: everything dropped while disabled
    cand_burst(8, 5);

    // R5: equal miss rates do not count as a benefit
    window(10, 5, 10, 5, "R5 equal rates keep disabled");

    // R10: a beneficial window switches prefetching back on
    window(10, 8, 20, 2, "R10 re-enable");
    cand_burst(4, 12);

    // R6, R7: no held-out accesses, enable kept
    window(0, 0, 12, 9, "R6 empty held class keeps enable");

    // R8: other accesses saturate at 31 (wrap would disable)
    window(10, 3, 70, 6, "R8 saturation keeps enable");

    // R9: fresh counts decide (stale counts would keep enable)
    window(2, 0, 2, 1, "R9 counters restart per window");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule